// File: doc/BRIEF.md
# Strap-Latched Test Clock Divider

This block is the configuration and production-test front end of a clock generator. While power-on reset is active, four shared pins are inputs. The block samples their levels on every reference-clock rising edge into a 4-bit configuration word. When power-on reset is released, a two-stage synchroniser aligns the release to the reference clock. The configuration word then freezes, and the shared pins are handed over to their clock-output role through an output-enable.

A small phase machine has three states:
- `PH_STRAP`: pins are inputs.
- `PH_TEST`: production test mode.
- `PH_NORMAL`: any other configuration.

It has two transitions, both taken on the edge after the synchronised release:
- `strap_to_test` when the frozen word matches the test code.
- `strap_to_normal` otherwise.

Asserting power-on reset returns the machine to `PH_STRAP` asynchronously from either running state.

In test mode the outputs are fixed fractions of the reference:
- Two outputs repeat the reference itself.
- One output divides by two and one divides by four.
- A bus clock divides by four when `bus_sel` is high and by three when it is low.

The divide-by-three clock uses a falling-edge stretcher so that it is high for one and a half reference periods. All dividers start from a known phase. Outside test mode every clock output is held low.

Top module: `strap_test_clkgen`

## Requirements
- R1: While `por_n` is low, `pin_oe`, `test_mode` and every clock output are 0; asserting `por_n` low forces this state asynchronously.
- R2: The configuration word follows `strap_pins` on each reference rising edge until the synchronised release. After that, pin changes have no effect until the next power-on reset.
- R3: After `por_n` rises between edges, `pin_oe` is 0 after the first and second following rising edges and 1 after the third (entry edge E0).
- R4: Test mode is entered only when configuration bits [2:0] equal 3'b110 (bit 2 = 1, bit 1 = 1, bit 0 = 0); bit 3 has no effect on the decision.
- R5: In test mode `ref_out` and `apic_out` equal the reference clock: 1 in its high phase, 0 in its low phase.
- R6: After the k-th rising edge following E0, `clk_div2` = k mod 2 and `clk_div4` = bit 1 of (k mod 4).
- R7: In test mode with `bus_sel` = 1, `bus_clk` equals `clk_div4`.
- R8: In test mode with `bus_sel` = 0, `bus_clk` is 1 from rising edge k with k mod 3 = 1 until the falling edge after rising edge k+1, and 0 otherwise (period 3, 50 percent duty).
- R9: After release with a non-test configuration, `pin_oe` is 1, `test_mode` is 0 and every clock output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_pins | input | 4 | Levels on the shared pins while they are inputs |
| bus_sel | input | 1 | Bus ratio select: 1 = divide by 4, 0 = divide by 3 |
| pin_oe | output | 1 | Output enable for the shared pins |
| test_mode | output | 1 | High while in production test mode |
| ref_out | output | 1 | Reference copy in test mode |
| apic_out | output | 1 | Second reference copy in test mode |
| clk_div2 | output | 1 | Reference divided by 2 |
| clk_div4 | output | 1 | Reference divided by 4 |
| bus_clk | output | 1 | Bus clock, divide by 4 or 3 |

## Verification
The assertions check the following on every cycle:
- the frozen configuration word stays stable once released;
- the test flag agrees with that word;
- the divide-by-2 output toggles and the divide-by-4 output follows it;
- the bus clock matches the divide-by-4 output when selected;
- the divide-by-3 bus clock is high at a rising edge only once in three;
- everything stays quiet in normal mode.

Only the bench scenarios can show the following:
- the exact release latency;
- which strap value is the last one captured;
- that bit 3 is ignored;
- the absolute divider phase after entry;
- the falling-edge half of the divide-by-3 waveform;
- that pin changes after release have no effect.

// File: rtl/stclk_pkg.sv
package stclk_pkg;
    localparam int CFG_W = 4;
    localparam logic [CFG_W-1:0] TEST_MASK = 4'b0111;
    localparam logic [CFG_W-1:0] TEST_CODE = 4'b0110;

    typedef enum logic [1:0] {
        PH_STRAP  = 2'd0,
        PH_TEST   = 2'd1,
        PH_NORMAL = 2'd2
    } phase_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int W     = 4,
    parameter int SYNC  = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] pins,
    output logic         run,
    output logic [W-1:0] cfg
);
    logic [SYNC-1:0] sync_q;
    logic [W-1:0]    cfg_q;

    // release synchroniser: asynchronous assert, synchronous release
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], 1'b1};
    end

    assign run = sync_q[SYNC-1];

    // sampled on every edge while pins are inputs, frozen once running
    always_ff @(posedge clk) begin
        if (!run) cfg_q <= pins;
    end

    assign cfg = cfg_q;

    // R2: configuration word never moves once released
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (run && $past(run)) |-> $stable(cfg_q));
endmodule

// File: rtl/ratio_counter.sv
module ratio_counter #(
    parameter int MOD = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    output logic [$clog2(MOD)-1:0] cnt
);
    localparam int CW = $clog2(MOD);
    localparam logic [CW-1:0] LAST = CW'(MOD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/duty_stretch.sv
module duty_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    output logic wave
);
    logic late_q;

    // half-period extension captured on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)   late_q <= 1'b0;
        else if (!en) late_q <= 1'b0;
        else          late_q <= hit;
    end

    assign wave = hit | late_q;

    // R8: at rising edges the stretched wave is never seen high twice running
    a_r8_single_rise_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(wave)) |-> !wave);
endmodule

// File: rtl/strap_test_clkgen.sv
module strap_test_clkgen
    import stclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             por_n,
    input  logic [CFG_W-1:0] strap_pins,
    input  logic             bus_sel,
    output logic             pin_oe,
    output logic             test_mode,
    output logic             ref_out,
    output logic             apic_out,
    output logic             clk_div2,
    output logic             clk_div4,
    output logic             bus_clk
);
    localparam int BIN_MOD = 4;
    localparam int ODD_MOD = 3;

    logic             run;
    logic [CFG_W-1:0] cfg;
    phase_e           phase_q, phase_d;
    logic             div_en;
    logic [$clog2(BIN_MOD)-1:0] bin_cnt;
    logic [$clog2(ODD_MOD)-1:0] odd_cnt;
    logic             odd_wave;
    logic             code_hit;

    strap_capture #(.W(CFG_W), .SYNC(SYNC_STAGES)) u_cap (
        .clk   (ref_clk),
        .por_n (por_n),
        .pins  (strap_pins),
        .run   (run),
        .cfg   (cfg)
    );

    assign code_hit = ((cfg & TEST_MASK) == TEST_CODE);

    // next-phase logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_STRAP:  if (run) phase_d = code_hit ? PH_TEST : PH_NORMAL;
            PH_TEST:   phase_d = PH_TEST;
            PH_NORMAL: phase_d = PH_NORMAL;
            default:   phase_d = PH_STRAP;
        endcase
    end

    // phase register
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) phase_q <= PH_STRAP;
        else        phase_q <= phase_d;
    end

    // phase outputs
    always_comb begin
        pin_oe    = 1'b0;
        test_mode = 1'b0;
        unique case (phase_q)
            PH_STRAP:  ;
            PH_TEST:   begin pin_oe = 1'b1; test_mode = 1'b1; end
            PH_NORMAL: pin_oe = 1'b1;
            default:   ;
        endcase
    end

    assign div_en = test_mode;

    ratio_counter #(.MOD(BIN_MOD)) u_bin (
        .clk   (ref_clk),
        .rst_n (por_n),
        .en    (div_en),
        .cnt   (bin_cnt)
    );

    ratio_counter #(.MOD(ODD_MOD)) u_odd (
        .clk   (ref_clk),
        .rst_n (por_n),
        .en    (div_en),
        .cnt   (odd_cnt)
    );

    duty_stretch u_str (
        .clk   (ref_clk),
        .rst_n (por_n),
        .en    (div_en),
        .hit   (odd_cnt == 2'd1),
        .wave  (odd_wave)
    );

    assign clk_div2 = bin_cnt[0];
    assign clk_div4 = bin_cnt[1];
    assign bus_clk  = bus_sel ? clk_div4 : odd_wave;
    assign ref_out  = ref_clk & test_mode;
    assign apic_out = ref_clk & test_mode;

    // R1: pins stay inputs and test flag stays low until handover
    a_r1_no_flag_before_oe: assert property (@(posedge ref_clk) disable iff (!por_n)
        !pin_oe |-> (!test_mode && !clk_div2 && !clk_div4 && !bus_clk));
    // R4: flag agrees with the frozen configuration word
    a_r4_flag_match: assert property (@(posedge ref_clk) disable iff (!por_n)
        pin_oe |-> (test_mode == (cfg[2] && cfg[1] && !cfg[0])));
    // R6: half-rate output toggles on every edge in test mode
    a_r6_half_toggles: assert property (@(posedge ref_clk) disable iff (!por_n)
        (test_mode && $past(test_mode)) |-> (clk_div2 != $past(clk_div2)));
    // R6: quarter-rate output moves only after the half-rate output was high
    a_r6_quarter_follows: assert property (@(posedge ref_clk) disable iff (!por_n)
        (test_mode && $past(test_mode)) |->
            ((clk_div4 != $past(clk_div4)) == $past(clk_div2)));
    // R7: slow bus select equals the quarter-rate output
    a_r7_bus_quarter: assert property (@(posedge ref_clk) disable iff (!por_n)
        (test_mode && bus_sel) |-> (bus_clk == clk_div4));
    // R9: normal mode keeps every clock quiet
    a_r9_quiet_normal: assert property (@(posedge ref_clk) disable iff (!por_n)
        (pin_oe && !test_mode) |->
            (!clk_div2 && !clk_div4 && !bus_clk && !ref_out && !apic_out));
endmodule

// File: tb/strap_test_clkgen_test.sv
`timescale 1ns/1ps
module strap_test_clkgen_test;
    logic       ref_clk = 1'b0;
    logic       por_n   = 1'b0;
    logic [3:0] strap_pins = 4'b0000;
    logic       bus_sel = 1'b1;
    logic pin_oe, test_mode, ref_out, apic_out, clk_div2, clk_div4, bus_clk;

    int total = 0;
    int bad   = 0;
    int kpos  = 0;
    bit finished = 1'b0;

    always #2.5 ref_clk = ~ref_clk;

    strap_test_clkgen uut (
        .ref_clk(ref_clk), .por_n(por_n), .strap_pins(strap_pins), .bus_sel(bus_sel),
        .pin_oe(pin_oe), .test_mode(test_mode), .ref_out(ref_out), .apic_out(apic_out),
        .clk_div2(clk_div2), .clk_div4(clk_div4), .bus_clk(bus_clk)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic all_quiet(input string tag);
        chk(clk_div2, 1'b0, {tag, " div2"});
        chk(clk_div4, 1'b0, {tag, " div4"});
        chk(bus_clk,  1'b0, {tag, " bus"});
        chk(ref_out,  1'b0, {tag, " ref"});
        chk(apic_out, 1'b0, {tag, " apic"});
    endtask

    // hold reset with given straps, release mid low phase, check R3 latency
    task automatic power_up(input logic [3:0] s);
        por_n = 1'b0;
        strap_pins = s;
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk); #1;
        chk(pin_oe, 1'b0, "R1 oe low in reset");
        chk(test_mode, 1'b0, "R1 flag low in reset");
        all_quiet("R1 reset");
        por_n = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(posedge ref_clk); #1;
            chk(pin_oe, (i == 3), "R3 release latency");
        end
        kpos = 0;
    endtask

    // advance n rising edges in test mode, checking R5-R8 on both phases
    task automatic run_test(input int n);
        for (int i = 0; i < n; i++) begin
            logic e2, e4, ebus;
            @(posedge ref_clk); #1;
            kpos++;
            e2 = ((kpos % 2) == 1);
            e4 = ((kpos % 4) >= 2);
            ebus = bus_sel ? e4 : ((kpos % 3) != 0);
            chk(test_mode, 1'b1, "R4 flag");
            chk(clk_div2, e2, "R6 div2");
            chk(clk_div4, e4, "R6 div4");
            chk(bus_clk, ebus, bus_sel ? "R7 bus/4 high phase" : "R8 bus/3 high phase");
            chk(ref_out, 1'b1, "R5 ref high");
            chk(apic_out, 1'b1, "R5 apic high");
            @(negedge ref_clk); #1;
            ebus = bus_sel ? e4 : ((kpos % 3) == 1);
            chk(bus_clk, ebus, bus_sel ? "R7 bus/4 low phase" : "R8 bus/3 low phase");
            chk(ref_out, 1'b0, "R5 ref low");
            chk(apic_out, 1'b0, "R5 apic low");
        end
    endtask

    task automatic t_test_quarter_bus();
        bus_sel = 1'b1;
        power_up(4'b0110);
        run_test(12);
    endtask

    task automatic t_test_third_bus();
        bus_sel = 1'b0;
        power_up(4'b0110);
        run_test(12);
    endtask

    task automatic t_bit3_ignored();
        bus_sel = 1'b0;
        power_up(4'b1110);
        chk(test_mode, 1'b1, "R4 bit3 ignored");
        run_test(6);
    endtask

    task automatic t_pins_ignored_after_release();
        bus_sel = 1'b1;
        power_up(4'b0110);
        run_test(3);
        strap_pins = 4'b0000;
        run_test(8);
        strap_pins = 4'b0101;
        run_test(4);
    endtask

    task automatic t_last_strap_wins();
        por_n = 1'b0;
        strap_pins = 4'b0101;
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk); #1;
        strap_pins = 4'b0110;
        por_n = 1'b1;
        // still inputs for the first sync edge: change is captured (R2)
        repeat (3) @(posedge ref_clk); #1;
        chk(test_mode, 1'b1, "R2 late strap captured");
        kpos = 0;
        bus_sel = 1'b1;
        run_test(4);
    endtask

    task automatic t_normal_mode(input logic [3:0] s);
        bus_sel = 1'b0;
        power_up(s);
        for (int i = 0; i < 10; i++) begin
            @(posedge ref_clk); #1;
            chk(pin_oe, 1'b1, "R9 oe high");
            chk(test_mode, 1'b0, "R9 flag low");
            all_quiet("R9 high phase");
            if (i == 4) strap_pins = 4'b0110;   // R2: no effect after release
        end
        @(negedge ref_clk); #1;
        chk(test_mode, 1'b0, "R2 late test code ignored");
        all_quiet("R9 low phase");
    endtask

    task automatic t_async_reset();
        bus_sel = 1'b1;
        power_up(4'b0110);
        run_test(5);
        @(posedge ref_clk); #1;
        por_n = 1'b0;
        #0.5;
        chk(pin_oe, 1'b0, "R1 async oe");
        chk(test_mode, 1'b0, "R1 async flag");
        all_quiet("R1 async");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_test_quarter_bus();
        t_test_third_bus();
        t_bit3_ignored();
        t_pins_ignored_after_release();
        t_last_strap_wins();
        t_normal_mode(4'b0101);
        t_normal_mode(4'b0111);
        t_normal_mode(4'b0010);
        t_async_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule